// File: doc/BRIEF.md
# DS3 Alarm Indication Signal Generator

This block produces an endless serial bitstream that carries the DS3 alarm indication signal. The stream is laid out as a DS3 M-frame of 4760 bits. The frame holds seven subframes. Each subframe holds eight blocks, and each block is one overhead bit followed by 84 payload bits. Every overhead bit has a fixed value. Every payload field carries an alternating one/zero pattern that starts again after each overhead bit.

The bit rate is set by a single-cycle strobe, `bit_en`:
- A downstream serializer or line encoder reads `ais_bit` on any cycle where it raises `bit_en`.
- The position counters step forward on that same clock edge.
- On cycles without the strobe, the presented bit and both markers hold their value.

This behaves like a ready signal from the consumer, with the output always valid while `enable` is high. The block never stalls, so there is no back-pressure to absorb.

Two markers travel with the data:
- `frame_start` flags the first bit of each frame.
- `ovh_mark` flags every overhead bit.

These let a downstream framer or monitor line up without searching for the frame. Pulling `enable` low forces all outputs to zero and parks the position at the first bit of the frame, so that transmission always begins with that bit.

Top module: `ds3_ais_gen`

## Requirements
- R1: The stream repeats every 4760 strobed bits. Position index n (0..4759) splits into subframe n/680, block (n mod 680)/85 and slot (n mod 85). Slot 0 is the overhead bit and slots 1..84 are payload. Bit 0 is the first bit sent after enable or reset.
- R2: The overhead bit of block 0 in subframes 0..6 takes the values 1,1,0,0,0,1,0 in that subframe order.
- R3: The overhead bits of blocks 1 and 7 are 1 in every subframe, and those of blocks 3 and 5 are 0.
- R4: The overhead bits of blocks 2, 4 and 6 are 0 in every subframe.
- R5: Payload slot s (1..84) carries 1 when s is odd and 0 when s is even, so the first payload bit after every overhead bit is 1.
- R6: The position advances by one only on a clock edge where `bit_en` and `enable` are both high. Otherwise `ais_bit`, `frame_start` and `ovh_mark` hold.
- R7: `frame_start` is 1 exactly at position 0 and is 0 everywhere else.
- R8: `ovh_mark` is 1 exactly at the 56 overhead positions (slot 0) and is 0 on payload.
- R9: While `enable` is low, all three outputs are 0 and the position returns to 0. After `enable` rises, the first bit presented is position 0.
- R10: A synchronous `rst` returns the position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit strobe: the current bit is taken and the position advances |
| enable | input | 1 | Generator on; low forces zero output and parks at frame start |
| ais_bit | output | 1 | Serial AIS data bit at the current position |
| frame_start | output | 1 | High on the first bit of the frame |
| ovh_mark | output | 1 | High on every overhead bit |

## Verification
The bench walks every one of the 4760 positions more than once, under a steady strobe and under a gapped strobe. It compares each presented bit against the position decoded arithmetically, so a swapped lead-bit value, a misplaced F bit, or a payload phase that fails to restart after an overhead bit shows up at the exact position. The gapped strobe exposes a counter that advances without `bit_en`: such a design would drift through the frame and mismatch within a few bits. A disable in mid-frame and a reset in mid-frame are each followed by a check for the frame-start bit. These catch a design that resumes from the old position, or that leaks data while disabled. The boundary at the last payload bit of subframe 6 is crossed repeatedly, which catches a frame length off by one.

// File: rtl/ds3_ais_pkg.sv
package ds3_ais_pkg;
  localparam int unsigned PAY_BITS  = 84;
  localparam int unsigned BLOCKS    = 8;
  localparam int unsigned SUBFRAMES = 7;
  // lead overhead bit per subframe, bit i = subframe i
  localparam logic [SUBFRAMES-1:0] LEAD_VALUES = 7'b0100011;
  // overhead value per block for blocks 1..7, bit b = block b (bit 0 unused: lead)
  localparam logic [BLOCKS-1:0] BLOCK_VALUES = 8'b1000_0010;
endpackage

// File: rtl/ais_slot_counter.sv
module ais_slot_counter #(
  parameter int unsigned PAY_BITS = ds3_ais_pkg::PAY_BITS,
  localparam int unsigned POS_W = $clog2(PAY_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  output logic [POS_W-1:0] pos_q,
  output logic             wrap
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PAY_BITS);

  assign wrap = en && step && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)   pos_q <= '0;
    else if (wrap)    pos_q <= '0;
    else if (step)    pos_q <= pos_q + 1'b1;
  end

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);
  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(pos_q));
  assert_slot_park_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pos_q == '0));
endmodule

// File: rtl/ais_frame_counter.sv
module ais_frame_counter #(
  parameter int unsigned BLOCKS    = ds3_ais_pkg::BLOCKS,
  parameter int unsigned SUBFRAMES = ds3_ais_pkg::SUBFRAMES,
  localparam int unsigned BLK_W = $clog2(BLOCKS),
  localparam int unsigned SF_W  = $clog2(SUBFRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv,
  output logic [BLK_W-1:0] blk_q,
  output logic [SF_W-1:0]  sf_q
);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      blk_q <= '0;
      sf_q  <= '0;
    end else if (adv) begin
      if (blk_q == BLK_LAST) begin
        blk_q <= '0;
        sf_q  <= (sf_q == SF_LAST) ? '0 : sf_q + 1'b1;
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end
  end

  assert_sf_range_R1: assert property (@(posedge clk) disable iff (rst)
    sf_q <= SF_LAST);
  assert_blk_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) |=> ($stable(blk_q) && $stable(sf_q)));
endmodule

// File: rtl/ais_bit_mapper.sv
module ais_bit_mapper #(
  parameter int unsigned PAY_BITS  = ds3_ais_pkg::PAY_BITS,
  parameter int unsigned BLOCKS    = ds3_ais_pkg::BLOCKS,
  parameter int unsigned SUBFRAMES = ds3_ais_pkg::SUBFRAMES,
  localparam int unsigned POS_W = $clog2(PAY_BITS + 1),
  localparam int unsigned BLK_W = $clog2(BLOCKS),
  localparam int unsigned SF_W  = $clog2(SUBFRAMES)
) (
  input  logic             en,
  input  logic [POS_W-1:0] pos,
  input  logic [BLK_W-1:0] blk,
  input  logic [SF_W-1:0]  sf,
  output logic             data,
  output logic             fstart,
  output logic             ovh
);
  logic is_ovh;
  logic ovh_val;

  assign is_ovh  = (pos == '0);
  assign ovh_val = (blk == '0) ? ds3_ais_pkg::LEAD_VALUES[sf]
                               : ds3_ais_pkg::BLOCK_VALUES[blk];

  always_comb begin
    data   = 1'b0;
    fstart = 1'b0;
    ovh    = 1'b0;
    if (en) begin
      ovh    = is_ovh;
      fstart = is_ovh && (blk == '0) && (sf == '0);
      data   = is_ovh ? ovh_val : pos[0];
    end
  end
endmodule

// File: rtl/ds3_ais_gen.sv
module ds3_ais_gen #(
  parameter int unsigned PAY_BITS  = ds3_ais_pkg::PAY_BITS,
  parameter int unsigned BLOCKS    = ds3_ais_pkg::BLOCKS,
  parameter int unsigned SUBFRAMES = ds3_ais_pkg::SUBFRAMES
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic enable,
  output logic ais_bit,
  output logic frame_start,
  output logic ovh_mark
);
  localparam int unsigned POS_W = $clog2(PAY_BITS + 1);
  localparam int unsigned BLK_W = $clog2(BLOCKS);
  localparam int unsigned SF_W  = $clog2(SUBFRAMES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PAY_BITS);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SUBFRAMES - 1);

  logic [POS_W-1:0] pos;
  logic [BLK_W-1:0] blk;
  logic [SF_W-1:0]  sf;
  logic             blk_adv;

  ais_slot_counter #(.PAY_BITS(PAY_BITS)) u_slot (
    .clk(clk), .rst(rst), .en(enable), .step(bit_en),
    .pos_q(pos), .wrap(blk_adv)
  );

  ais_frame_counter #(.BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES)) u_frame (
    .clk(clk), .rst(rst), .en(enable), .adv(blk_adv),
    .blk_q(blk), .sf_q(sf)
  );

  ais_bit_mapper #(.PAY_BITS(PAY_BITS), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES)) u_map (
    .en(enable), .pos(pos), .blk(blk), .sf(sf),
    .data(ais_bit), .fstart(frame_start), .ovh(ovh_mark)
  );

  assert_first_pay_one_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && bit_en && ovh_mark) |=> (!enable || ais_bit));
  assert_pay_alternate_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && bit_en && !ovh_mark && pos != POS_LAST)
      |=> (!enable || (ais_bit != $past(ais_bit))));
  assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && bit_en && pos == POS_LAST && blk == BLK_LAST && sf == SF_LAST)
      |=> (!enable || frame_start));
  assert_fs_is_ovh_R8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ovh_mark);
  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!ais_bit && !frame_start && !ovh_mark));
  assert_reset_park_R10: assert property (@(posedge clk)
    rst |=> (pos == '0 && blk == '0 && sf == '0));
endmodule

// File: tb/tb_ds3_ais_gen.sv
`timescale 1ns/1ps
module tb_ds3_ais_gen;
  localparam int FRAME = 4760;
  localparam int SUBF  = 680;
  localparam int BLK   = 85;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic enable = 1'b0;
  logic ais_bit, frame_start, ovh_mark;

  int n_checks = 0;
  int n_fail   = 0;
  int n        = 0;   // model position
  logic last_s = 1'b0;
  int lead [7] = '{1, 1, 0, 0, 0, 1, 0};

  always #10 clk = ~clk;

  ds3_ais_gen dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .enable(enable),
    .ais_bit(ais_bit), .frame_start(frame_start), .ovh_mark(ovh_mark)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input int pos);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, pos, act, exp);
    end
  endtask

  // check presented outputs against the model, using the enable currently applied
  task automatic check_now();
    int sf, r, bk, p, eb;
    string tag;
    if (!enable) begin
      chk(ais_bit, 1'b0, "R9 data off", n);
      chk(frame_start, 1'b0, "R9 fs off", n);
      chk(ovh_mark, 1'b0, "R9 ovh off", n);
      return;
    end
    sf = n / SUBF; r = n % SUBF; bk = r / BLK; p = r % BLK;
    if (p != 0) begin eb = p % 2; tag = "R5 payload"; end
    else if (bk == 0) begin eb = lead[sf]; tag = "R2 lead"; end
    else if (bk == 1 || bk == 7) begin eb = 1; tag = "R3 F one"; end
    else if (bk == 3 || bk == 5) begin eb = 0; tag = "R3 F zero"; end
    else begin eb = 0; tag = "R4 C bit"; end
    if (!last_s) tag = {tag, " R6 hold"};
    chk(ais_bit, eb[0], tag, n);
    chk(frame_start, (n == 0), "R7 frame_start", n);
    chk(ovh_mark, (p == 0), "R8 ovh_mark", n);
  endtask

  task automatic cyc(input logic s, input logic e, input logic r);
    @(negedge clk);
    check_now();
    bit_en = s; enable = e; rst = r;
    last_s = s;
    if (r || !e) n = 0;
    else if (s) n = (n + 1) % FRAME;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R9: reset held, disabled: quiet outputs
    repeat (3) cyc(1'b0, 1'b0, 1'b1);
    // R10: enabled under reset presents position 0
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk(frame_start, 1'b1, "R10 reset fs", 0);
    chk(ais_bit, 1'b1, "R10 reset X1", 0);
    // R1: one full frame plus wrap, steady strobe
    for (int i = 0; i < FRAME + 20; i++) cyc(1'b1, 1'b1, 1'b0);
    // R6: gapped strobe over two frames
    for (int i = 0; i < 3 * FRAME; i++) cyc((i % 3) != 1, 1'b1, 1'b0);
    // R9: disable in mid-frame
    for (int i = 0; i < 1234; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(frame_start, 1'b1, "R9 restart fs", n);
    chk(ais_bit, 1'b1, "R9 restart X1", n);
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, 1'b0);
    // R10: reset in mid-frame while enabled
    cyc(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk(frame_start, 1'b1, "R10 midframe reset fs", n);
    chk(ovh_mark, 1'b1, "R10 midframe reset ovh", n);
    for (int i = 0; i < 700; i++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule